// File: doc/BRIEF.md
# Complex Result Scaler and Selector

This block is the back end of a complex multiplier. It receives the full-precision 32-bit real and imaginary sums together. It scales both by the same power of two, chosen by a 2-bit code: one place left, no shift, one place right, or two places right. It can round the upper 16-bit word of each component. It then presents two chosen 16-bit halves of the scaled pair on two registered output ports. A flag is registered with the data. It marks a result made invalid by the left shift or by a rounding carry into the sign.

The scale code, the rounding control and the half select are not registered. They are sampled at the clock edge that accepts a word. A producer can therefore offer the same complex word twice with two different selects. This delivers all 64 scaled bits over two transfers, either as real/imaginary pairs or as whole 32-bit components.

Data enters and leaves through valid/ready handshakes, with one output register between them. A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output data and flag hold. `in_ready` stays low during that time.

Top module: `cplx_result_scaler`

## Requirements
- R1: With scale code 2'b00, each 32-bit component passes unchanged to the split stage.
- R2: With scale code 2'b11, each component is shifted left by one bit and a zero enters bit 0.
- R3: Scale code 2'b01 shifts each component right by one bit and 2'b10 by two bits, arithmetically, copying the sign bit into the vacated positions.
- R4: The real and imaginary components always receive the same scaling in one transfer.
- R5: `out_ovf` is 1 when the scale code is 2'b11 and either component has bit 31 different from bit 30.
- R6: With `round_en` high, each upper half becomes bits 31:16 of the scaled word plus bit 15 of that word. The lower halves are never altered. With `round_en` low, the upper half is taken as is.
- R7: `out_ovf` is also 1 when rounding is on, the scaled upper half of either component is 16'h7FFF, and bit 15 is set; that upper half then wraps to 16'h8000.
- R8: Select `out_sel` = 00 puts real-high on `out_a` and imag-high on `out_b`. Select 01 gives real-high and real-low. Select 10 gives real-low and imag-low. Select 11 gives imag-high and imag-low.
- R9: Scale code, `round_en` and `out_sel` are used in the accepting cycle only, so back-to-back transfers of one word with different selects return different halves.
- R10: Accepted data and its flag appear on the outputs, with `out_valid` high, one rising edge after acceptance.
- R11: While `out_valid` is high and `out_ready` low, `in_ready` is low and `out_a`, `out_b`, `out_ovf` hold; a held word leaves once `out_ready` rises.
- R12: After reset, `out_valid`, `out_a`, `out_b` and `out_ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers a complex word |
| in_ready | output | 1 | Block can accept this cycle |
| in_re | input | 32 | Real full-precision sum, two's complement |
| in_im | input | 32 | Imaginary full-precision sum, two's complement |
| scale_code | input | 2 | 11 left 1, 00 none, 01 right 1, 10 right 2 |
| round_en | input | 1 | Round the upper halves |
| out_sel | input | 2 | Half routing select (R8) |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_a | output | 16 | First selected half |
| out_b | output | 16 | Second selected half |
| out_ovf | output | 1 | Result invalid from shift or rounding |

## Verification
Every result is due exactly one rising edge after the edge that accepts it. Only the output register lies between the accepting edge and the ports. The bench drives a word on a falling edge and lets one rising edge accept it. It samples `out_a`, `out_b`, `out_ovf` and `out_valid` on the next falling edge, half a cycle after they settle. The back-pressure scenario extends this by counting held edges. It samples on the falling edge after each held edge, and again after the edge on which `out_ready` releases the next word.

// File: rtl/cplx_scale_pkg.sv
package cplx_scale_pkg;

  typedef enum logic [1:0] {
    SC_NONE = 2'b00,
    SC_RSH1 = 2'b01,
    SC_RSH2 = 2'b10,
    SC_LSH1 = 2'b11
  } scale_e;

  typedef enum logic [1:0] {
    PICK_HIGHS = 2'b00,
    PICK_REAL  = 2'b01,
    PICK_LOWS  = 2'b10,
    PICK_IMAG  = 2'b11
  } pick_e;

  localparam int unsigned LANES   = 2;
  localparam int unsigned LANE_RE = 0;
  localparam int unsigned LANE_IM = 1;

endpackage

// File: rtl/cplx_scale_lane.sv
module cplx_scale_lane
  import cplx_scale_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]   x,
  input  scale_e         code,
  input  logic           round_en,
  output logic [W/2-1:0] hi,
  output logic [W/2-1:0] lo,
  output logic           ovf
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] s;
  logic [H-1:0] up;
  logic         rnd_bit;
  logic         shift_bad;
  logic         round_bad;

  // arithmetic scaling, identical code for every lane
  always_comb begin
    unique case (code)
      SC_LSH1: s = {x[W-2:0], 1'b0};
      SC_RSH1: s = {x[W-1], x[W-1:1]};
      SC_RSH2: s = {{2{x[W-1]}}, x[W-1:2]};
      default: s = x;
    endcase
  end

  assign shift_bad = (code == SC_LSH1) && (x[W-1] != x[W-2]);

  assign up        = s[W-1:H];
  assign rnd_bit   = round_en & s[H-1];
  assign round_bad = rnd_bit && (up == {1'b0, {(H-1){1'b1}}});

  assign hi  = up + {{(H-1){1'b0}}, rnd_bit};
  assign lo  = s[H-1:0];
  assign ovf = shift_bad | round_bad;

endmodule

// File: rtl/cplx_half_pick.sv
module cplx_half_pick
  import cplx_scale_pkg::*;
#(
  parameter int unsigned H = 16
) (
  input  pick_e        sel,
  input  logic [H-1:0] re_hi,
  input  logic [H-1:0] re_lo,
  input  logic [H-1:0] im_hi,
  input  logic [H-1:0] im_lo,
  output logic [H-1:0] a,
  output logic [H-1:0] b
);
  always_comb begin
    unique case (sel)
      PICK_HIGHS: begin a = re_hi; b = im_hi; end
      PICK_REAL:  begin a = re_hi; b = re_lo; end
      PICK_LOWS:  begin a = re_lo; b = im_lo; end
      default:    begin a = im_hi; b = im_lo; end
    endcase
  end
endmodule

// File: rtl/cplx_out_stage.sv
module cplx_out_stage #(
  parameter int unsigned H = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [H-1:0] d_a,
  input  logic [H-1:0] d_b,
  input  logic         d_ovf,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [H-1:0] q_a,
  output logic [H-1:0] q_b,
  output logic         q_ovf
);
  logic take;

  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      q_a      <= '0;
      q_b      <= '0;
      q_ovf    <= 1'b0;
    end else begin
      if (take) begin
        dn_valid <= 1'b1;
        q_a      <= d_a;
        q_b      <= d_b;
        q_ovf    <= d_ovf;
      end else if (dn_ready) begin
        dn_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cplx_result_scaler.sv
module cplx_result_scaler
  import cplx_scale_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_re,
  input  logic [W-1:0]   in_im,
  input  logic [1:0]     scale_code,
  input  logic           round_en,
  input  logic [1:0]     out_sel,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W/2-1:0] out_a,
  output logic [W/2-1:0] out_b,
  output logic           out_ovf
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] lane_x   [LANES];
  logic [H-1:0] lane_hi  [LANES];
  logic [H-1:0] lane_lo  [LANES];
  logic         lane_ovf [LANES];

  logic [H-1:0] pick_a;
  logic [H-1:0] pick_b;
  logic         any_ovf;

  assign lane_x[LANE_RE] = in_re;
  assign lane_x[LANE_IM] = in_im;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cplx_scale_lane #(.W(W)) u_lane (
      .x        (lane_x[g]),
      .code     (scale_e'(scale_code)),
      .round_en (round_en),
      .hi       (lane_hi[g]),
      .lo       (lane_lo[g]),
      .ovf      (lane_ovf[g])
    );
  end

  assign any_ovf = lane_ovf[LANE_RE] | lane_ovf[LANE_IM];

  cplx_half_pick #(.H(H)) u_pick (
    .sel   (pick_e'(out_sel)),
    .re_hi (lane_hi[LANE_RE]),
    .re_lo (lane_lo[LANE_RE]),
    .im_hi (lane_hi[LANE_IM]),
    .im_lo (lane_lo[LANE_IM]),
    .a     (pick_a),
    .b     (pick_b)
  );

  cplx_out_stage #(.H(H)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .d_a      (pick_a),
    .d_b      (pick_b),
    .d_ovf    (any_ovf),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .q_a      (out_a),
    .q_b      (out_b),
    .q_ovf    (out_ovf)
  );
endmodule

// File: rtl/cplx_result_scaler_chk.sv
module cplx_result_scaler_chk #(
  parameter int unsigned W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   in_re,
  input logic [W-1:0]   in_im,
  input logic [1:0]     scale_code,
  input logic           round_en,
  input logic [1:0]     out_sel,
  input logic           out_valid,
  input logic           out_ready,
  input logic [W/2-1:0] out_a,
  input logic [W/2-1:0] out_b,
  input logic           out_ovf
);
  localparam int unsigned H = W / 2;

  logic acc;
  assign acc = in_valid && in_ready;

  AST_PASS_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    acc && scale_code == 2'b00 && !round_en && out_sel == 2'b01
    |=> out_a == $past(in_re[W-1:H]) && out_b == $past(in_re[H-1:0]) && !out_ovf); // R1

  AST_LEFT_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    acc && scale_code == 2'b11 && (in_re[W-1] ^ in_re[W-2])
    |=> out_ovf); // R5

  AST_RIGHT_LOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && scale_code == 2'b01 && out_sel == 2'b10
    |=> out_a == $past(in_re[H:1]) && out_b == $past(in_im[H:1])); // R3

  AST_LOW_UNROUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    acc && scale_code == 2'b00 && round_en && out_sel == 2'b11
    |=> out_b == $past(in_im[H-1:0])); // R6

  AST_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R10

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready
    |=> out_valid && $stable(out_a) && $stable(out_b) && $stable(out_ovf)); // R11

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R11
endmodule

bind cplx_result_scaler cplx_result_scaler_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_re      (in_re),
  .in_im      (in_im),
  .scale_code (scale_code),
  .round_en   (round_en),
  .out_sel    (out_sel),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_a      (out_a),
  .out_b      (out_b),
  .out_ovf    (out_ovf)
);

// File: tb/test_cplx_result_scaler.sv
`timescale 1ns/1ps
module test_cplx_result_scaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_re = '0;
  logic [31:0] in_im = '0;
  logic [1:0]  scale_code = 2'b00;
  logic        round_en = 1'b0;
  logic [1:0]  out_sel = 2'b00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_a;
  logic [15:0] out_b;
  logic        out_ovf;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cplx_result_scaler i_cplx_result_scaler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .scale_code(scale_code), .round_en(round_en),
    .out_sel(out_sel), .out_valid(out_valid), .out_ready(out_ready),
    .out_a(out_a), .out_b(out_b), .out_ovf(out_ovf)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model built from the requirement text
  function automatic logic [31:0] m_scale(logic [31:0] x, logic [1:0] c);
    longint v = longint'($signed(x));
    longint r;
    case (c)
      2'b11:   r = v * 2;
      2'b01:   r = v >>> 1;
      2'b10:   r = v >>> 2;
      default: r = v;
    endcase
    return r[31:0];
  endfunction

  function automatic bit m_lovf(logic [31:0] x, logic [1:0] c);
    longint v = longint'($signed(x)) * 2;
    return (c == 2'b11) && (v > 64'sd2147483647 || v < -64'sd2147483648);
  endfunction

  function automatic logic [15:0] m_hi(logic [31:0] s, bit rnd);
    return s[31:16] + ((rnd && s[15]) ? 16'd1 : 16'd0);
  endfunction

  function automatic bit m_rovf(logic [31:0] s, bit rnd);
    int t = int'($signed(s[31:16])) + ((rnd && s[15]) ? 1 : 0);
    return t > 32767;
  endfunction

  task automatic xfer(string req, logic [31:0] re, logic [31:0] im,
                      logic [1:0] c, bit rnd, logic [1:0] sel);
    logic [31:0] sr, si;
    logic [15:0] ea, eb;
    bit eo;
    sr = m_scale(re, c);
    si = m_scale(im, c);
    case (sel)
      2'b00:   begin ea = m_hi(sr, rnd); eb = m_hi(si, rnd); end
      2'b01:   begin ea = m_hi(sr, rnd); eb = sr[15:0];      end
      2'b10:   begin ea = sr[15:0];      eb = si[15:0];      end
      default: begin ea = m_hi(si, rnd); eb = si[15:0];      end
    endcase
    eo = m_lovf(re, c) | m_lovf(im, c) | m_rovf(sr, rnd) | m_rovf(si, rnd);
    @(negedge clk);
    in_valid = 1'b1; in_re = re; in_im = im;
    scale_code = c; round_en = rnd; out_sel = sel;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "out_valid", {31'd0, out_valid}, 32'd1);
    chk(req, "out_a", {16'd0, out_a}, {16'd0, ea});
    chk(req, "out_b", {16'd0, out_b}, {16'd0, eb});
    chk(req, "out_ovf", {31'd0, out_ovf}, {31'd0, eo});
  endtask

  task automatic t_reset();
    chk("R12", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R12", "out_a", {16'd0, out_a}, 32'd0);
    chk("R12", "out_b", {16'd0, out_b}, 32'd0);
    chk("R12", "out_ovf", {31'd0, out_ovf}, 32'd0);
  endtask

  task automatic t_passthrough_selects();
    xfer("R1_R8_sel00", 32'h1234_5678, 32'h9ABC_DEF0, 2'b00, 1'b0, 2'b00);
    xfer("R1_R8_sel01", 32'h1234_5678, 32'h9ABC_DEF0, 2'b00, 1'b0, 2'b01);
    xfer("R1_R8_sel10", 32'h1234_5678, 32'h9ABC_DEF0, 2'b00, 1'b0, 2'b10);
    xfer("R9_sel11", 32'h1234_5678, 32'h9ABC_DEF0, 2'b00, 1'b0, 2'b11);
  endtask

  task automatic t_left();
    xfer("R2_clean", 32'h2000_0001, 32'hC000_0003, 2'b11, 1'b0, 2'b01);
    xfer("R2_imag", 32'h2000_0001, 32'hC000_0003, 2'b11, 1'b0, 2'b11);
    xfer("R5_real", 32'h4000_0000, 32'h0000_0010, 2'b11, 1'b0, 2'b00);
    xfer("R5_imag", 32'h0000_0010, 32'hA000_0000, 2'b11, 1'b0, 2'b10);
    xfer("R5_noshift", 32'h4000_0000, 32'hA000_0000, 2'b00, 1'b0, 2'b00);
  endtask

  task automatic t_right();
    xfer("R3_r1_highs", 32'h8000_0003, 32'h7FFF_FFFF, 2'b01, 1'b0, 2'b00);
    xfer("R3_r1_lows", 32'h8000_0003, 32'h7FFF_FFFF, 2'b01, 1'b0, 2'b10);
    xfer("R3_r2_highs", 32'h8000_0003, 32'hF000_000C, 2'b10, 1'b0, 2'b00);
    xfer("R4_r2_lows", 32'h8000_0003, 32'hF000_000C, 2'b10, 1'b0, 2'b10);
  endtask

  task automatic t_round();
    xfer("R6_up", 32'h0001_8000, 32'h0002_7FFF, 2'b00, 1'b1, 2'b00);
    xfer("R6_off", 32'h0001_8000, 32'h0002_7FFF, 2'b00, 1'b0, 2'b00);
    xfer("R6_low_kept", 32'h0001_8000, 32'h0002_7FFF, 2'b00, 1'b1, 2'b01);
    xfer("R6_neg", 32'hFFFF_8000, 32'h0000_0000, 2'b00, 1'b1, 2'b00);
    xfer("R6_after_left", 32'h0000_4000, 32'h0000_0000, 2'b11, 1'b1, 2'b00);
    xfer("R7_real", 32'h7FFF_8000, 32'h0000_0000, 2'b00, 1'b1, 2'b00);
    xfer("R7_imag", 32'h0000_0000, 32'h7FFF_C000, 2'b00, 1'b1, 2'b11);
    xfer("R7_off", 32'h7FFF_8000, 32'h0000_0000, 2'b00, 1'b0, 2'b00);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_re = 32'hAAAA_5555; in_im = 32'h0;
    scale_code = 2'b00; round_en = 1'b0; out_sel = 2'b01;
    @(posedge clk);
    @(negedge clk);
    chk("R10", "out_valid", {31'd0, out_valid}, 32'd1);
    chk("R10", "out_a", {16'd0, out_a}, 32'h0000_AAAA);
    in_re = 32'h1111_2222;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R11", "in_ready", {31'd0, in_ready}, 32'd0);
      chk("R11", "out_a", {16'd0, out_a}, 32'h0000_AAAA);
      chk("R11", "out_b", {16'd0, out_b}, 32'h0000_5555);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11", "released_a", {16'd0, out_a}, 32'h0000_1111);
    chk("R11", "released_b", {16'd0, out_b}, 32'h0000_2222);
    @(posedge clk);
    @(negedge clk);
    chk("R10", "drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_passthrough_selects();
    t_left();
    t_right();
    t_round();
    t_backpressure();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule